// File: doc/BRIEF.md
# Pipelined Accumulate-and-Dump Unit with Output Rounding

This block sums a stream of signed 24-bit products into a 27-bit register. The three extra bits absorb overflow. The adder carry chain is cut into short bit segments, and each segment has a register. The longest path is therefore the add inside one segment, whatever the total width. Each operand enters the lowest segment first and reaches each higher segment one cycle later, together with the carry from the segment below. A deskew triangle realigns the segment results into one word before output.

A caller marks the final operand of a sum with `in_last`. The flag travels down the pipeline with that operand. When it comes out it pulses `out_valid` on the same cycle that the finished sum sits on `out_sum`. Clearing is done by zeroing the fed-back value that each segment sees on the operand after a flagged one, so the next sum can start on the very next cycle. On the flagged operand only, a 3-bit select can ask for a shorter rounded result: a single one is added just below the kept width, and the bits under that width are forced to zero in a registered output stage. Both input and output are valid/ready streams. `in_ready` equals `out_ready`. When the consumer drops `out_ready`, the whole pipeline freezes, including the output registers. When `in_valid` is low on an advancing cycle, the pipeline advances with a zero operand.

Top module: `acc_dump_pipe`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sum` is 0, and the first accepted operand starts a sum from zero.
- R2: `in_ready` always equals `out_ready`. An operand is accepted only on a rising edge with `in_valid` and `in_ready` both high. While `out_ready` is low, `out_valid` and `out_sum` keep their values.
- R3: Each product is sign-extended from bit 23. A dumped sum equals the total of every product accepted since the previous flagged operand, up to and including the flagged one, taken modulo 2^27.
- R4: For an operand accepted with `in_last` high, `out_valid` is high after exactly 10 advancing edges that follow the accepting edge. An advancing edge is a rising edge with `out_ready` high. The pulse lasts one advancing cycle.
- R5: The operand after a flagged one starts a new sum with no gap. With `in_last` high on every operand, each output is that operand's own product, rounded per R7.
- R6: An advancing cycle with `in_valid` low adds nothing to the sum in progress, whatever `in_prod` carries.
- R7: `round_sel` = 0 gives the full 27-bit sum with no rounding. `round_sel` = n, for n from 1 to 7, keeps the upper 14+n bits. It adds 1 at bit 12-n, then outputs zero in bits 0 to 12-n.
- R8: `round_sel` is used only on the flagged operand. Its value on other operands has no effect.
- R9: `out_valid` rises only for a flagged operand, once per flagged operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken (equals out_ready) |
| in_prod | input | 24 | Signed product |
| in_last | input | 1 | Operand closes the current sum |
| round_sel | input | 3 | Width and rounding select, used with the flagged operand |
| out_valid | output | 1 | Finished sum present |
| out_ready | input | 1 | Consumer can take a result; low freezes the pipeline |
| out_sum | output | 27 | Finished, rounded and masked sum |

## Verification
A segment that failed to clear its feedback would leak the old total into the next sum, and the next dumped value would be wrong. A carry lost between segments shows as an error in a power-of-8 position of the same result. A skew or deskew register of the wrong depth mixes bits from neighbouring sums, or moves the valid pulse away from the tenth advancing edge. Each of these faults therefore appears at the first dump that follows it, roughly ten cycles after the flagged operand. Rounding and masking faults show only when a non-zero select comes with the flagged operand. For that reason, the stimulus places round-up and round-down boundary values on flagged operands and varies the select on the operands that are not flagged.

// File: rtl/adp_pkg.sv
package adp_pkg;
  typedef logic [2:0] rsel_t;

  // Number of low result bits dropped for a select; zero means full width.
  function automatic int drop_bits(input rsel_t sel, input int acc_w, input int min_keep);
    if (sel == 3'd0) return 0;
    return acc_w - (min_keep - 1 + int'(sel));
  endfunction
endpackage

// File: rtl/adp_skew_line.sv
module adp_skew_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/adp_acc_slice.sv
module adp_acc_slice #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] op,
  input  logic [W-1:0] rnd,
  input  logic         last,
  input  logic [1:0]   cin,
  output logic [W-1:0] acc_q,
  output logic [1:0]   cout
);
  logic         endq;   // previous operand in this segment closed a sum
  logic [W-1:0] fb;
  logic [W+1:0] total;

  // Clear acts on the loop path only: incoming operand is never gated.
  assign fb    = endq ? '0 : acc_q;
  assign total = {2'b00, fb} + {2'b00, op} + {2'b00, rnd} + {{W{1'b0}}, cin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cout  <= 2'b00;
      endq  <= 1'b0;
    end else if (en) begin
      acc_q <= total[W-1:0];
      cout  <= total[W+1:W];
      endq  <= last;
    end
  end
endmodule

// File: rtl/adp_out_stage.sv
module adp_out_stage #(
  parameter int ACC_W    = 27,
  parameter int MIN_KEEP = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dv,
  input  adp_pkg::rsel_t   sel,
  input  logic [ACC_W-1:0] word,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_sum
);
  localparam logic [ACC_W-1:0] ONE = 1;

  int               drop;
  logic [ACC_W-1:0] low_mask;
  logic [ACC_W-1:0] masked;

  always_comb begin
    drop     = adp_pkg::drop_bits(sel, ACC_W, MIN_KEEP);
    low_mask = (ONE << drop) - ONE;
    masked   = word & ~low_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (en) begin
      out_valid <= dv;
      if (dv) out_sum <= masked;
    end
  end

  // R7: any shortened width leaves the result LSB cleared
  p_lsb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && dv && (sel != 3'd0) |=> out_sum[0] == 1'b0);
endmodule

// File: rtl/acc_dump_pipe.sv
module acc_dump_pipe #(
  parameter int PROD_W   = 24,
  parameter int ACC_W    = 27,
  parameter int SEG_W    = 3,   // ACC_W must be a multiple of SEG_W
  parameter int MIN_KEEP = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PROD_W-1:0] in_prod,
  input  logic              in_last,
  input  logic [2:0]        round_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_sum
);
  localparam int NSEG   = ACC_W / SEG_W;
  localparam int LAT    = NSEG + 2;
  localparam int PAY_W  = 2 * SEG_W + 1;
  localparam int PEND_W = $clog2(LAT + 2) + 1;
  localparam logic [ACC_W-1:0]  ONE      = 1;
  localparam logic [PEND_W-1:0] PEND_ONE = 1;

  logic             en, take;
  int               drop_in;
  logic [ACC_W-1:0] ext_in, rnd_in;
  logic [ACC_W-1:0] s0_op, s0_rnd;
  logic             s0_last;
  adp_pkg::rsel_t   s0_sel;
  logic [1:0]       cy [NSEG+1];
  logic [SEG_W-1:0] seg_acc [NSEG];
  logic [SEG_W-1:0] seg_al  [NSEG];
  logic [ACC_W-1:0] aligned;
  logic [3:0]       tail;

  assign en       = out_ready;
  assign in_ready = out_ready;
  assign take     = in_valid & out_ready;
  assign ext_in   = {{(ACC_W-PROD_W){in_prod[PROD_W-1]}}, in_prod};
  assign cy[0]    = 2'b00;

  // Rounding one rides with the flagged operand only.
  always_comb begin
    drop_in = adp_pkg::drop_bits(round_sel, ACC_W, MIN_KEEP);
    rnd_in  = '0;
    if (take && in_last && drop_in > 0) rnd_in = ONE << (drop_in - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_op   <= '0;
      s0_rnd  <= '0;
      s0_last <= 1'b0;
      s0_sel  <= '0;
    end else if (en) begin
      s0_op   <= take ? ext_in : '0;
      s0_rnd  <= rnd_in;
      s0_last <= take & in_last;
      s0_sel  <= take ? round_sel : 3'd0;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [PAY_W-1:0] pay_in, pay;
    assign pay_in = {s0_op[s*SEG_W +: SEG_W], s0_rnd[s*SEG_W +: SEG_W], s0_last};

    if (s == 0) begin : g_direct
      assign pay = pay_in;
    end else begin : g_skew
      adp_skew_line #(.W(PAY_W), .DEPTH(s)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(en), .d(pay_in), .q(pay));
    end

    adp_acc_slice #(.W(SEG_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .en(en),
      .op(pay[PAY_W-1:SEG_W+1]), .rnd(pay[SEG_W:1]), .last(pay[0]),
      .cin(cy[s]), .acc_q(seg_acc[s]), .cout(cy[s+1]));

    if (s == NSEG - 1) begin : g_top
      assign seg_al[s] = seg_acc[s];
    end else begin : g_deskew
      adp_skew_line #(.W(SEG_W), .DEPTH(NSEG - 1 - s)) u_deskew (
        .clk(clk), .rst_n(rst_n), .en(en), .d(seg_acc[s]), .q(seg_al[s]));
    end

    // R3: three addends plus carry never need more than two carry bits
    p_carry_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cy[s+1] != 2'b11);
  end

  always_comb begin
    for (int s = 0; s < NSEG; s++) aligned[s*SEG_W +: SEG_W] = seg_al[s];
  end

  adp_skew_line #(.W(4), .DEPTH(NSEG)) u_tail (
    .clk(clk), .rst_n(rst_n), .en(en), .d({s0_last, s0_sel}), .q(tail));

  adp_out_stage #(.ACC_W(ACC_W), .MIN_KEEP(MIN_KEEP)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .dv(tail[3]), .sel(tail[2:0]),
    .word(aligned), .out_valid(out_valid), .out_sum(out_sum));

  // Checker state: flagged operands accepted but not yet consumed at the output.
  logic [PEND_W-1:0] pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if ((take && in_last) && !(out_valid && out_ready)) pend <= pend + PEND_ONE;
    else if (!(take && in_last) && (out_valid && out_ready)) pend <= pend - PEND_ONE;
  end

  // R1: reset leaves the output idle
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2: a stalled consumer sees a frozen output
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(out_valid) && $stable(out_sum));

  // R9: every valid pulse is owed to an accepted flagged operand
  p_valid_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend != '0);
endmodule

// File: tb/sim_acc_dump_pipe.sv
module sim_acc_dump_pipe;
  localparam int NSEG = 9;
  localparam int LATE = NSEG + 1;
  localparam int NVEC = 20;
  // {last, sel[2:0], prod[23:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 24'h000010}, {1'b0, 3'd0, 24'h000020}, {1'b1, 3'd0, 24'h000005},
    {1'b1, 3'd0, 24'hFFFFFF}, {1'b0, 3'd3, 24'h001234}, {1'b0, 3'd5, 24'h000FFF},
    {1'b1, 3'd1, 24'h000800}, {1'b1, 3'd7, 24'h7FFFFF}, {1'b0, 3'd2, 24'h800000},
    {1'b0, 3'd6, 24'h800000}, {1'b1, 3'd4, 24'h123456}, {1'b1, 3'd7, 24'h000020},
    {1'b1, 3'd7, 24'h00001F}, {1'b1, 3'd7, 24'hFFFFE0}, {1'b1, 3'd7, 24'hFFFFDF},
    {1'b0, 3'd2, 24'h0ABCDE}, {1'b0, 3'd6, 24'hF00000}, {1'b1, 3'd0, 24'h000001},
    {1'b1, 3'd1, 24'h3FFFFF}, {1'b1, 3'd0, 24'h000000}};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [23:0] in_prod = '0;
  logic [2:0]  round_sel = '0;
  logic        in_ready, out_valid;
  logic [26:0] out_sum;

  int nchk = 0, nbad = 0, adv = 0;
  bit done = 1'b0;
  string phase = "R1";
  bit [26:0] run = '0;
  bit [26:0] q_sum [$];
  int        q_due [$];
  bit        prev_v = 1'b0;
  bit [26:0] prev_s = '0;

  acc_dump_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_prod(in_prod), .in_last(in_last), .round_sel(round_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s/%s actual=%0h expected=%0h", phase, req, act, exp);
    end
  endtask

  task automatic model(input bit [23:0] p, input bit l, input bit [2:0] s);
    bit [26:0] x, t;
    int d;
    x = {{3{p[23]}}, p};
    if (l) begin
      t = run + x;
      if (s != 3'd0) begin
        d = 27 - (14 + int'(s));
        t = t + (27'd1 << (d - 1));
        t = t & ~((27'd1 << d) - 27'd1);
      end
      q_sum.push_back(t);
      q_due.push_back(adv + LATE);
      run = '0;
    end else begin
      run = run + x;
    end
  endtask

  task automatic observe(input bit moved);
    bit [26:0] e;
    int du;
    if (!moved) begin
      chk(out_valid == prev_v && out_sum == prev_s, "R2 stall hold", {4'd0, out_valid, out_sum}, {4'd0, prev_v, prev_s});
    end else if (out_valid) begin
      if (q_sum.size() == 0) chk(1'b0, "R9 unexpected valid", 1, 0);
      else begin
        e  = q_sum.pop_front();
        du = q_due.pop_front();
        chk(out_sum == e, "R3/R7 sum", out_sum, e);
        chk(du == adv, "R4 latency", adv, du);
      end
    end else if (q_due.size() > 0 && q_due[0] <= adv) begin
      chk(1'b0, "R4 valid missing", adv, q_due[0]);
      void'(q_sum.pop_front());
      void'(q_due.pop_front());
    end
    prev_v = out_valid;
    prev_s = out_sum;
  endtask

  task automatic cyc(input bit v, input bit [23:0] p, input bit l, input bit [2:0] s, input bit rdy);
    in_valid = v; in_prod = p; in_last = l; round_sel = s; out_ready = rdy;
    #1;
    chk(in_ready == rdy, "R2 in_ready", in_ready, rdy);
    @(posedge clk);
    if (rdy) adv++;
    if (v && rdy) model(p, l, s);
    @(negedge clk);
    observe(rdy);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run = '0;
    q_sum.delete();
    q_due.delete();
    prev_v = 1'b0;
    prev_s = '0;
    chk(out_valid == 1'b0 && out_sum == '0, "R1 reset state", {4'd0, out_valid, out_sum}, 0);
  endtask

  task automatic drain();
    repeat (LATE + 3) cyc(1'b0, 24'h0, 1'b0, 3'd0, 1'b1);
    chk(q_sum.size() == 0, "R4 drained", q_sum.size(), 0);
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    do_reset();
    cyc(1'b0, 24'h0, 1'b0, 3'd0, 1'b0);  // R2: in_ready low with out_ready low

    // Table walk; select varies on operands that are not flagged (R8)
    phase = "R8";
    for (int i = 0; i < NVEC; i++)
      cyc(1'b1, VEC[i][23:0], VEC[i][27], VEC[i][26:24], 1'b1);
    drain();

    // R5: every operand flagged, back-to-back single-operand sums
    phase = "R5";
    for (int i = 0; i < 12; i++)
      cyc(1'b1, 24'h00F0F0 + 24'(i * 24'h031337), 1'b1, 3'(i % 8), 1'b1);
    drain();

    // R6: idle cycles carrying junk do not count
    phase = "R6";
    cyc(1'b1, 24'h000100, 1'b0, 3'd0, 1'b1);
    cyc(1'b0, 24'h7ABCDE, 1'b1, 3'd5, 1'b1);
    cyc(1'b0, 24'h555555, 1'b0, 3'd0, 1'b1);
    cyc(1'b1, 24'h000011, 1'b0, 3'd0, 1'b1);
    cyc(1'b0, 24'hFFFFFF, 1'b1, 3'd0, 1'b1);
    cyc(1'b1, 24'h000002, 1'b1, 3'd0, 1'b1);
    drain();

    // R3: free run wraps modulo 2^27
    phase = "R3";
    for (int i = 0; i < 40; i++) cyc(1'b1, 24'h7FFFFF, 1'b0, 3'd0, 1'b1);
    cyc(1'b1, 24'h7FFFFF, 1'b1, 3'd0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b1, 24'h800000, 1'b0, 3'd0, 1'b1);
    cyc(1'b1, 24'h800000, 1'b1, 3'd3, 1'b1);
    drain();

    // R2: stall with results in flight and one on the output
    phase = "R2";
    for (int i = 0; i < 12; i++) cyc(1'b1, 24'h000040 + 24'(i), 1'b1, 3'd0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 24'h0FFFFF, 1'b1, 3'd2, 1'b0);
    cyc(1'b1, 24'h000003, 1'b0, 3'd0, 1'b1);
    cyc(1'b0, 24'h0, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 24'h000004, 1'b1, 3'd0, 1'b1);
    drain();

    // R1: reset in the middle of a sum discards it
    phase = "R1";
    for (int i = 0; i < 6; i++) cyc(1'b1, 24'h012345, 1'b0, 3'd0, 1'b1);
    do_reset();
    cyc(1'b1, 24'h000123, 1'b1, 3'd0, 1'b1);
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule